// File: doc/BRIEF.md
# Line Zero-Crossing and Frequency Detector

This block watches three signed phase-voltage samples that arrive at a fixed high rate, one set per `smp_vld_i` pulse. For each sample it forms a single reference value by subtracting the second and third phase from the first. Only the sign of that reference is kept. A rising transition of the sign (from non-positive to positive) is a candidate line-cycle boundary. Once a boundary is accepted, further candidates are suppressed for three quarters of a line cycle so that noise and harmonics near the crossing cannot produce extra boundaries.

The number of samples between consecutive accepted boundaries is the measured line period. A shared serial divider turns that period into a frequency value in fixed point (`FREQ_FRAC` fractional bits of hertz). A mode input selects what the frequency output holds. In one mode the measured value replaces it after every measurement. In the other mode it keeps a value written through a small write port. After reset it holds the 60 Hz default. Before any period has been measured, the suppression window is derived from whatever frequency the output currently holds.

A programmable limit flags a missing line: when too many samples pass without an accepted boundary, a timeout flag rises. The first boundary after a timeout only restarts the measurement.

Top module: `line_zc_freq`

## Requirements
- R1: The reference is `va_i - vb_i - vc_i`, computed at full precision. A sample is a rising crossing candidate when the previous sample's reference was zero or negative and the current one is strictly positive. A reference of exactly zero counts as non-positive. Directly after reset the previous sign is taken as positive.
- R2: Every accepted crossing produces `zc_o` high for exactly one clock, in the clock that follows the edge that captured the crossing sample.
- R3: `period_o` changes only together with `zc_o`. It then equals the count of samples from the previous accepted crossing to this one (indices differ by `period_o`). The first accepted crossing after reset, and the first after a timeout, leave `period_o` unchanged. It resets to 0.
- R4: After an accepted crossing, candidates in the next H samples are ignored and the sample after them may be accepted. H = floor(3*P/4). P is the period just measured, or else the last measured period. Before any measurement, P = floor(SAMPLE_HZ*2^FREQ_FRAC / freq_o).
- R5: The internal sample count saturates at 2^PER_W-1, so a crossing measured after a longer gap reports `period_o` = 2^PER_W-1 when the timeout is disabled.
- R6: With `tmo_lim_i` nonzero, `timeout_o` rises after the sample at which the count since the last accepted crossing reaches `tmo_lim_i`. The next accepted crossing clears it. A limit of 0 disables the flag.
- R7: With `freq_mode_i` = 0, `freq_o` becomes floor(SAMPLE_HZ*2^FREQ_FRAC / period_o) within DVD_W+3 clocks of each updating crossing, saturated to 2^FREQ_W-1.
- R8: With `freq_mode_i` = 1, `freq_o` takes `freq_wdata_i` on a `freq_wr_i` pulse and otherwise holds. Measurements do not change it. A write made while `freq_mode_i` = 0 is ignored.
- R9: After reset, `freq_o` equals DEF_HZ*2^FREQ_FRAC (960 with defaults), `period_o` is 0, and `zc_o` and `timeout_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld_i | input | 1 | One-clock pulse marking a new sample set |
| va_i | input | SMP_W | First phase sample, signed |
| vb_i | input | SMP_W | Second phase sample, signed |
| vc_i | input | SMP_W | Third phase sample, signed |
| freq_mode_i | input | 1 | 0: measured frequency replaces output; 1: written value is kept |
| freq_wr_i | input | 1 | Write strobe for the frequency value |
| freq_wdata_i | input | FREQ_W | Frequency value to write, fixed point |
| tmo_lim_i | input | PER_W | Sample limit for the timeout flag, 0 disables |
| zc_o | output | 1 | Accepted rising crossing strobe |
| period_o | output | PER_W | Last measured line period in samples |
| freq_o | output | FREQ_W | Active frequency value, fixed point |
| timeout_o | output | 1 | No accepted crossing within the limit |

## Verification
A wrong suppression window shows within a single line cycle. A glitch is then either reported as an extra `zc_o`, or a real boundary just past the window is dropped and the next `period_o` doubles. A corrupted sample count or previous-sign register appears on the next `zc_o` as a `period_o` off by the error. A fault in the divider job sequencing or the mode selection appears on `freq_o` a few tens of clocks after an updating crossing, as a value that does not match the quotient. It can also appear as a change while the written value should be held.

// File: rtl/lzc_pkg.sv
package lzc_pkg;

  // Which computation the shared divider is currently serving.
  typedef enum logic {
    JOB_EST  = 1'b0,   // period estimate from the active frequency
    JOB_MEAS = 1'b1    // frequency from a measured period
  } div_job_e;

endpackage

// File: rtl/lzc_phase_ref.sv
module lzc_phase_ref #(
  parameter int SMP_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_vld_i,
  input  logic signed [SMP_W-1:0] va_i,
  input  logic signed [SMP_W-1:0] vb_i,
  input  logic signed [SMP_W-1:0] vc_i,
  output logic                    rise_o
);

  localparam int REF_W = SMP_W + 2;

  logic signed [REF_W-1:0] ref_s;
  logic                    cur_pos;
  logic                    prev_pos_q, prev_pos_d;

  // Two guard bits keep the three-term difference exact.
  assign ref_s = {{2{va_i[SMP_W-1]}}, va_i}
               - {{2{vb_i[SMP_W-1]}}, vb_i}
               - {{2{vc_i[SMP_W-1]}}, vc_i};

  assign cur_pos = !ref_s[REF_W-1] && (ref_s != '0);

  always_comb begin
    prev_pos_d = prev_pos_q;
    if (smp_vld_i) prev_pos_d = cur_pos;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_pos_q <= 1'b1;
    else         prev_pos_q <= prev_pos_d;
  end

  assign rise_o = smp_vld_i && !prev_pos_q && cur_pos;

endmodule

// File: rtl/lzc_cycle_timer.sv
module lzc_cycle_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic             rise_i,
  input  logic [PER_W-1:0] tmo_lim_i,
  input  logic             est_we_i,
  input  logic [PER_W-1:0] est_per_i,
  output logic             zc_o,
  output logic             meas_o,
  output logic [PER_W-1:0] period_o,
  output logic             have_o,
  output logic             timeout_o
);

  localparam logic [PER_W-1:0] CNT_MAX = '1;

  logic             zc_q, zc_d;
  logic             meas_q, meas_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] hold_q, hold_d;
  logic [PER_W-1:0] ref_q, ref_d;
  logic             armed_q, armed_d;
  logic             to_q, to_d;
  logic             have_q, have_d;
  logic             accept;

  function automatic logic [PER_W-1:0] three_qtr(input logic [PER_W-1:0] p);
    logic [PER_W+1:0] t;
    t = {2'b00, p} + {1'b0, p, 1'b0};
    return t[PER_W+1:2];
  endfunction

  assign accept = rise_i && (hold_q == '0);

  always_comb begin
    zc_d    = 1'b0;
    meas_d  = 1'b0;
    per_d   = per_q;
    cnt_d   = cnt_q;
    hold_d  = hold_q;
    ref_d   = ref_q;
    armed_d = armed_q;
    to_d    = to_q;
    have_d  = have_q;
    if (est_we_i && !have_q) ref_d = est_per_i;
    if (smp_vld_i) begin
      if (accept) begin
        zc_d    = 1'b1;
        cnt_d   = {{(PER_W-1){1'b0}}, 1'b1};
        armed_d = 1'b1;
        to_d    = 1'b0;
        if (armed_q && !to_q) begin
          per_d  = cnt_q;
          meas_d = 1'b1;
          have_d = 1'b1;
          ref_d  = cnt_q;
          hold_d = three_qtr(cnt_q);
        end else begin
          hold_d = three_qtr(ref_d);
        end
      end else begin
        if (hold_q != '0)   hold_d = hold_q - 1'b1;
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        if ((tmo_lim_i != '0) && (cnt_q >= tmo_lim_i)) to_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zc_q    <= 1'b0;
      meas_q  <= 1'b0;
      per_q   <= '0;
      cnt_q   <= '0;
      hold_q  <= '0;
      ref_q   <= '0;
      armed_q <= 1'b0;
      to_q    <= 1'b0;
      have_q  <= 1'b0;
    end else begin
      zc_q    <= zc_d;
      meas_q  <= meas_d;
      per_q   <= per_d;
      cnt_q   <= cnt_d;
      hold_q  <= hold_d;
      ref_q   <= ref_d;
      armed_q <= armed_d;
      to_q    <= to_d;
      have_q  <= have_d;
    end
  end

  assign zc_o      = zc_q;
  assign meas_o    = meas_q;
  assign period_o  = per_q;
  assign have_o    = have_q;
  assign timeout_o = to_q;

endmodule

// File: rtl/lzc_divider.sv
module lzc_divider #(
  parameter int DVD_W = 16,
  parameter int DSR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dvd_i,
  input  logic [DSR_W-1:0] dsr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);

  localparam int CNT_W = $clog2(DVD_W + 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DSR_W-1:0] rem_q, rem_d;
  logic [DSR_W-1:0] dsr_q, dsr_d;
  logic [DVD_W-1:0] acc_q, acc_d;
  logic [DSR_W:0]   shf;
  logic [DSR_W-1:0] dif;
  logic             ge;

  // Restoring division, one quotient bit per clock, shifted into acc.
  assign shf = {rem_q, acc_q[DVD_W-1]};
  assign ge  = shf >= {1'b0, dsr_q};
  assign dif = shf[DSR_W-1:0] - dsr_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    dsr_d  = dsr_q;
    acc_d  = acc_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(DVD_W);
      rem_d  = '0;
      dsr_d  = dsr_i;
      acc_d  = dvd_i;
    end else if (busy_q) begin
      acc_d = {acc_q[DVD_W-2:0], ge};
      rem_d = ge ? dif : shf[DSR_W-1:0];
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      dsr_q  <= '0;
      acc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      dsr_q  <= dsr_d;
      acc_q  <= acc_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = acc_q;

endmodule

// File: rtl/line_zc_freq.sv
module line_zc_freq #(
  parameter int SMP_W     = 16,
  parameter int PER_W     = 16,
  parameter int FREQ_W    = 16,
  parameter int FREQ_FRAC = 4,
  parameter int SAMPLE_HZ = 4000,
  parameter int DEF_HZ    = 60
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_vld_i,
  input  logic signed [SMP_W-1:0] va_i,
  input  logic signed [SMP_W-1:0] vb_i,
  input  logic signed [SMP_W-1:0] vc_i,
  input  logic                    freq_mode_i,
  input  logic                    freq_wr_i,
  input  logic [FREQ_W-1:0]       freq_wdata_i,
  input  logic [PER_W-1:0]        tmo_lim_i,
  output logic                    zc_o,
  output logic [PER_W-1:0]        period_o,
  output logic [FREQ_W-1:0]       freq_o,
  output logic                    timeout_o
);

  import lzc_pkg::*;

  localparam int                KDIV      = SAMPLE_HZ * (2 ** FREQ_FRAC);
  localparam int                DVD_W     = $clog2(KDIV + 1);
  localparam logic [DVD_W-1:0]  KDIV_V    = DVD_W'(KDIV);
  localparam logic [FREQ_W-1:0] FREQ_DEF  = FREQ_W'(DEF_HZ * (2 ** FREQ_FRAC));
  localparam longint unsigned   FREQ_MAX  = (64'd1 << FREQ_W) - 64'd1;
  localparam longint unsigned   PER_MAX   = (64'd1 << PER_W) - 64'd1;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  logic              rise;
  logic              meas;
  logic              have_meas;
  logic              est_we;
  logic [PER_W-1:0]  est_per;
  logic              div_start, div_busy, div_done;
  logic              est_start;
  logic [FREQ_W-1:0] div_dsr;
  logic [DVD_W-1:0]  div_quot;
  logic [63:0]       quot_w;
  logic [FREQ_W-1:0] quot_fsat;
  div_job_e          job_q, job_d;
  logic [FREQ_W-1:0] freq_q, freq_d;

  lzc_phase_ref #(.SMP_W(SMP_W)) i_phase_ref (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .smp_vld_i (smp_vld_i),
    .va_i      (va_i),
    .vb_i      (vb_i),
    .vc_i      (vc_i),
    .rise_o    (rise)
  );

  lzc_cycle_timer #(.PER_W(PER_W)) i_cycle_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .smp_vld_i (smp_vld_i),
    .rise_i    (rise),
    .tmo_lim_i (tmo_lim_i),
    .est_we_i  (est_we),
    .est_per_i (est_per),
    .zc_o      (zc_o),
    .meas_o    (meas),
    .period_o  (period_o),
    .have_o    (have_meas),
    .timeout_o (timeout_o)
  );

  // A measurement preempts any estimate in flight; estimates repeat
  // back to back until the first period is measured.
  assign est_start = !div_busy && !have_meas && !meas;
  assign div_start = meas || est_start;
  assign div_dsr   = meas ? FREQ_W'(period_o) : freq_q;

  lzc_divider #(.DVD_W(DVD_W), .DSR_W(FREQ_W)) i_divider (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .start_i (div_start),
    .dvd_i   (KDIV_V),
    .dsr_i   (div_dsr),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quot_o  (div_quot)
  );

  assign quot_w    = 64'(div_quot);
  assign quot_fsat = (quot_w > FREQ_MAX) ? '1 : quot_w[FREQ_W-1:0];
  assign est_per   = (quot_w > PER_MAX)  ? '1 : quot_w[PER_W-1:0];
  assign est_we    = div_done && (job_q == JOB_EST);

  always_comb begin
    job_d = job_q;
    if (meas)           job_d = JOB_MEAS;
    else if (est_start) job_d = JOB_EST;
  end

  always_comb begin
    freq_d = freq_q;
    if (freq_mode_i) begin
      if (freq_wr_i) freq_d = freq_wdata_i;
    end else if (div_done && (job_q == JOB_MEAS)) begin
      freq_d = quot_fsat;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      job_q  <= JOB_EST;
      freq_q <= FREQ_DEF;
    end else begin
      job_q  <= job_d;
      freq_q <= freq_d;
    end
  end

  assign freq_o = freq_q;

endmodule

// File: rtl/lzc_checker.sv
module lzc_checker #(
  parameter int PER_W  = 16,
  parameter int FREQ_W = 16
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              smp_vld_i,
  input logic              freq_mode_i,
  input logic              freq_wr_i,
  input logic              zc_o,
  input logic              timeout_o,
  input logic [PER_W-1:0]  period_o,
  input logic [FREQ_W-1:0] freq_o
);

  AST_ZC_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    zc_o |=> !zc_o); // R2

  AST_ZC_AFTER_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    zc_o |-> $past(smp_vld_i)); // R2

  AST_PERIOD_ONLY_ON_ZC: assert property (@(posedge clk_i) disable iff (!rst_n)
    !zc_o |-> $stable(period_o)); // R3

  AST_PERIOD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (zc_o && !$stable(period_o)) |-> (period_o != '0)); // R3

  AST_TIMEOUT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_n)
    zc_o |-> !timeout_o); // R6

  AST_USER_FREQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(freq_mode_i) && !$past(freq_wr_i)) |-> $stable(freq_o)); // R8

endmodule

bind line_zc_freq lzc_checker #(.PER_W(PER_W), .FREQ_W(FREQ_W)) i_lzc_checker (
  .clk_i       (clk_i),
  .rst_n       (rst_n_s),
  .smp_vld_i   (smp_vld_i),
  .freq_mode_i (freq_mode_i),
  .freq_wr_i   (freq_wr_i),
  .zc_o        (zc_o),
  .timeout_o   (timeout_o),
  .period_o    (period_o),
  .freq_o      (freq_o)
);

// File: tb/test_line_zc_freq.sv
`timescale 1ns/1ps
module test_line_zc_freq;

  localparam int SMP_W  = 16;
  localparam int PER_W  = 10;
  localparam int FREQ_W = 16;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    smp_vld;
  logic signed [SMP_W-1:0] va, vb, vc;
  logic                    freq_mode;
  logic                    freq_wr;
  logic [FREQ_W-1:0]       freq_wdata;
  logic [PER_W-1:0]        tmo_lim;
  logic                    zc;
  logic [PER_W-1:0]        period;
  logic [FREQ_W-1:0]       freq;
  logic                    timeout;

  always #10 clk = ~clk;

  line_zc_freq #(.SMP_W(SMP_W), .PER_W(PER_W), .FREQ_W(FREQ_W)) i_line_zc_freq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .smp_vld_i    (smp_vld),
    .va_i         (va),
    .vb_i         (vb),
    .vc_i         (vc),
    .freq_mode_i  (freq_mode),
    .freq_wr_i    (freq_wr),
    .freq_wdata_i (freq_wdata),
    .tmo_lim_i    (tmo_lim),
    .zc_o         (zc),
    .period_o     (period),
    .freq_o       (freq),
    .timeout_o    (timeout)
  );

  typedef struct { int idx; int per; string req; } exp_t;
  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  int   sidx = 0;
  int   cur_idx = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: every strobe must match the next scoreboard entry.
  always @(negedge clk) begin
    if (rst_n && zc) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected crossing at sample %0d actual=1 expected=0", cur_idx);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.idx != cur_idx || e.per != int'(period)) begin
          errors++;
          $display("FAIL %s sample/period actual=%0d/%0d expected=%0d/%0d",
                   e.req, cur_idx, period, e.idx, e.per);
        end
      end
    end
  end

  // Driver: one sample set every four clocks.
  task automatic smp(int a, int b, int c, bit ex, int per, string req);
    @(negedge clk);
    va = SMP_W'(a); vb = SMP_W'(b); vc = SMP_W'(c);
    smp_vld = 1'b1;
    cur_idx = sidx;
    if (ex) q.push_back('{sidx, per, req});
    @(negedge clk);
    smp_vld = 1'b0;
    sidx++;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Styles: 0 first phase only, 1 all three phases (R1), 2 zero low half (R1)
  task automatic pos_smp(int sty, bit ex, int per, string req);
    if (sty == 1) smp(-100, -150, -50, ex, per, req);
    else          smp(1000, 0, 0, ex, per, req);
  endtask

  task automatic neg_smp(int sty);
    if (sty == 1)      smp(100, 150, 0, 1'b0, 0, "");
    else if (sty == 2) smp(0, 0, 0, 1'b0, 0, "");
    else               smp(-1000, 0, 0, 1'b0, 0, "");
  endtask

  task automatic wave(int np, int nn, int sty, bit ex, int per, string req);
    pos_smp(sty, ex, per, req);
    for (int i = 1; i < np; i++) pos_smp(sty, 1'b0, 0, "");
    for (int i = 0; i < nn; i++) neg_smp(sty);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_freq(int v);
    @(negedge clk);
    freq_wr = 1'b1; freq_wdata = FREQ_W'(v);
    @(negedge clk);
    freq_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; smp_vld = 1'b0; va = '0; vb = '0; vc = '0;
    freq_mode = 1'b0; freq_wr = 1'b0; freq_wdata = '0; tmo_lim = '0;
    do_reset();
    chk("R9 freq", int'(freq), 960);
    chk("R9 period", int'(period), 0);
    chk("R9 timeout", int'(timeout), 0);
    chk("R9 zc", int'(zc), 0);

    // Scenario A: measured mode, default estimate gives holdoff 49
    for (int i = 0; i < 10; i++) neg_smp(0);
    wave(40, 40, 0, 1'b1, 0, "R3 first");
    for (int i = 0; i < 3; i++) wave(40, 40, 0, 1'b1, 80, "R3 period80");
    chk("R7 freq 80", int'(freq), 800);
    // glitch at offset 8 is inside the holdoff
    pos_smp(0, 1'b1, 80, "R3 period80");
    for (int i = 0; i < 4; i++) pos_smp(0, 1'b0, 0, "");
    for (int i = 0; i < 3; i++) neg_smp(0);
    pos_smp(0, 1'b0, 0, "");
    for (int i = 0; i < 31; i++) pos_smp(0, 1'b0, 0, "");
    for (int i = 0; i < 40; i++) neg_smp(0);
    wave(35, 35, 2, 1'b1, 80, "R1 zero low half");
    wave(35, 35, 0, 1'b1, 70, "R4 shorter period");
    // holdoff now 52: rise at 52 dropped, rise at 54 accepted
    pos_smp(0, 1'b1, 70, "R3 period70");
    for (int i = 1; i < 20; i++) pos_smp(0, 1'b0, 0, "");
    for (int i = 0; i < 32; i++) neg_smp(0);
    pos_smp(0, 1'b0, 0, "");
    neg_smp(0);
    pos_smp(0, 1'b1, 54, "R4 holdoff edge");
    for (int i = 0; i < 20; i++) neg_smp(0);
    chk("R7 freq 54", int'(freq), 1185);
    chk("R4 queue drained", q.size(), 0);

    // Scenario B: user mode, estimate 40 gives holdoff 30
    do_reset();
    chk("R9 freq after reset", int'(freq), 960);
    chk("R9 period after reset", int'(period), 0);
    freq_mode = 1'b1;
    wr_freq(1600);
    chk("R8 write", int'(freq), 1600);
    for (int i = 0; i < 10; i++) neg_smp(1);
    wave(20, 15, 1, 1'b1, 0, "R1 three phase first");
    wave(20, 15, 1, 1'b1, 35, "R4 estimate holdoff");
    wave(20, 15, 1, 1'b1, 35, "R1 three phase");
    chk("R8 held over measurement", int'(freq), 1600);
    freq_mode = 1'b0;
    wave(20, 15, 1, 1'b1, 35, "R3 period35");
    chk("R7 freq 35", int'(freq), 1828);
    wr_freq(500);
    repeat (3) @(negedge clk);
    chk("R8 write ignored", int'(freq), 1828);

    // Timeout and saturation
    tmo_lim = PER_W'(200);
    smp(1000, 0, 0, 1'b1, 35, "R3 before timeout");
    for (int i = 0; i < 199; i++) neg_smp(0);
    chk("R6 below limit", int'(timeout), 0);
    neg_smp(0);
    chk("R6 at limit", int'(timeout), 1);
    smp(1000, 0, 0, 1'b1, 35, "R6 restart keeps period");
    chk("R6 cleared", int'(timeout), 0);
    tmo_lim = '0;
    for (int i = 0; i < 1500; i++) neg_smp(0);
    chk("R6 disabled", int'(timeout), 0);
    smp(1000, 0, 0, 1'b1, 1023, "R5 saturated");
    for (int i = 0; i < 10; i++) neg_smp(0);
    chk("R7 freq saturated", int'(freq), 62);
    chk("R3 queue drained", q.size(), 0);
    finish_run();
  end

endmodule